// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Protection

This block caches page table entries so that a virtual page number can be turned into a physical address without walking the page tables. Every stored entry is compared against the requested page number and the current process tag at once, and the result (hit, protection fault, physical address and the entry's modify bit) is reported combinationally in the same cycle as the request. The physical address is the stored frame number joined to the untranslated page offset.

Each entry carries a process tag, read, write, execute and user permission bits, and reference and modify bits. A hit whose access type or privilege level is not allowed by the entry reports a protection fault in place of a translation. Separate inputs fill an entry after a miss, drop the entries of one page across all process tags, and flush the whole cache. On a fill the hardware picks the victim with a not-recently-used policy. The page walk and the fault handling live outside the block.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no entry is valid: every lookup reports lk_hit=0, lk_fault=0, lk_dirty=0 and lk_paddr=0.
- R2: A lookup hits only when a valid entry matches both lk_vpn and lk_asid; on a permitted hit lk_paddr is {stored frame, lk_offset} in the same cycle.
- R3: Permission field bit 0 allows read, bit 1 write, bit 2 execute, bit 3 user access; lk_acc is 0 read, 1 write, 2 execute, 3 reserved (never permitted). With lk_user=1 the user bit is also required. A hit that is not permitted reports lk_hit=1, lk_fault=1, lk_paddr=0.
- R4: A permitted hit sets the entry's reference bit and a permitted write also sets its modify bit; lk_dirty reports the modify bit held before the current access.
- R5: A fill takes effect for lookups in the following cycle; a lookup of the same page in the fill cycle sees the earlier state and misses.
- R6: A fill whose page number and process tag match a valid entry overwrites that entry in place, with the modify bit cleared, and creates no duplicate.
- R7: Otherwise a fill goes to the lowest-indexed invalid entry if one exists.
- R8: When all entries are valid the victim is the lowest-indexed entry with its reference bit clear; a fill sets the reference bit of its entry, and whenever all reference bits would be set, all are cleared except those of the entries touched in that cycle.
- R9: An invalidate clears every entry with the given page number, under any process tag, from the next cycle; other entries remain.
- R10: A flush clears every entry from the next cycle and overrides a fill in the same cycle.
- R11: With lk_valid=0 the outputs are all zero and no reference or modify bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Current process tag |
| lk_offset | input | OFF_W | Page offset of the request |
| lk_acc | input | 2 | Access type (0 read, 1 write, 2 execute) |
| lk_user | input | 1 | Request from user mode |
| lk_hit | output | 1 | Matching valid entry found |
| lk_fault | output | 1 | Hit with an access the entry forbids |
| lk_dirty | output | 1 | Modify bit of the matching entry |
| lk_paddr | output | PFN_W+OFF_W | Physical address on a permitted hit, else 0 |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Process tag to install |
| fill_pfn | input | PFN_W | Physical frame to install |
| fill_perm | input | 4 | Permission bits to install |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | VPN_W | Page number to invalidate |
| flush | input | 1 | Clear all entries |

## Verification
Lookup results are combinational, so they are due in the cycle of the request, while every state change caused by a fill, invalidate, flush or permitted hit becomes visible to lookups one rising edge later. The bench changes inputs on the falling edge, compares the outputs against its own model one nanosecond later, and only after the next rising edge applies the same request to the model, so each comparison sees exactly the state left by the previous cycle. Same-cycle fill and lookup, and the replacement order once the cache is full, are driven as directed sequences before a long random mix.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PERM_W = 4;
  localparam int PERM_R = 0;
  localparam int PERM_W_BIT = 1;
  localparam int PERM_X = 2;
  localparam int PERM_U = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES  = 32,
  parameter int VPN_W    = 20,
  parameter int ASID_W   = 8,
  parameter bit USE_ASID = 1'b1
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [VPN_W-1:0]   vpn_tab  [ENTRIES],
  input  logic [ASID_W-1:0]  asid_tab [ENTRIES],
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [ASID_W-1:0]  key_asid,
  output logic [ENTRIES-1:0] match
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    if (USE_ASID) begin : g_tag
      assign match[i] = vld[i] && (vpn_tab[i] == key_vpn) && (asid_tab[i] == key_asid);
    end else begin : g_notag
      logic unused_asid;
      assign unused_asid = ^asid_tab[i] ^ ^key_asid;
      assign match[i] = vld[i] && (vpn_tab[i] == key_vpn);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] refd,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] nru_idx, inv_idx;
  logic             any_inv;

  always_comb begin
    nru_idx = '0;
    inv_idx = '0;
    any_inv = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!refd[i]) nru_idx = IDX_W'(i);
      if (!vld[i]) begin
        inv_idx = IDX_W'(i);
        any_inv = 1'b1;
      end
    end
    idx = any_inv ? inv_idx : nru_idx;
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [ASID_W-1:0]      lk_asid,
  input  logic [OFF_W-1:0]       lk_offset,
  input  logic [1:0]             lk_acc,
  input  logic                   lk_user,
  output logic                   lk_hit,
  output logic                   lk_fault,
  output logic                   lk_dirty,
  output logic [PFN_W+OFF_W-1:0] lk_paddr,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [PERM_W-1:0]      fill_perm,
  input  logic                   inv_valid,
  input  logic [VPN_W-1:0]       inv_vpn,
  input  logic                   flush
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld_q, vld_d, ref_q, ref_d, mod_q, mod_d;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fill_match, inv_match;
  logic [ENTRIES-1:0] hit_mask, fill_mask, wr_en, touched;
  logic [IDX_W-1:0]   victim;
  logic [PFN_W-1:0]   pfn_sel;
  logic [PERM_W-1:0]  perm_sel;
  logic               dirty_sel, any_hit, need_ok, acc_ok;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .USE_ASID(1'b1)) u_lk_cmp (
    .vld(vld_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match));

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .USE_ASID(1'b1)) u_fill_cmp (
    .vld(vld_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .match(fill_match));

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .USE_ASID(1'b0)) u_inv_cmp (
    .vld(vld_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(inv_vpn), .key_asid(lk_asid), .match(inv_match));

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .vld(vld_q), .refd(ref_q), .idx(victim));

  // Lookup path: at most one entry matches, so the fields are OR-combined.
  always_comb begin
    pfn_sel   = '0;
    perm_sel  = '0;
    dirty_sel = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        pfn_sel   |= pfn_q[i];
        perm_sel  |= perm_q[i];
        dirty_sel |= mod_q[i];
      end
    end
    any_hit = lk_valid && (|lk_match);
    case (acc_e'(lk_acc))
      ACC_READ:  need_ok = perm_sel[PERM_R];
      ACC_WRITE: need_ok = perm_sel[PERM_W_BIT];
      ACC_EXEC:  need_ok = perm_sel[PERM_X];
      default:   need_ok = 1'b0;
    endcase
    acc_ok   = need_ok && (!lk_user || perm_sel[PERM_U]);
    lk_hit   = any_hit;
    lk_fault = any_hit && !acc_ok;
    lk_dirty = any_hit && dirty_sel;
    lk_paddr = (any_hit && acc_ok) ? {pfn_sel, lk_offset} : '0;
    hit_mask = (any_hit && acc_ok) ? lk_match : '0;
  end

  // Next-state of the per-entry status bits.
  always_comb begin
    fill_mask = (|fill_match) ? fill_match : (ENTRIES'(1) << victim);
    wr_en     = (fill_valid && !flush) ? fill_mask : '0;
    vld_d     = vld_q;
    ref_d     = ref_q | hit_mask;
    mod_d     = mod_q | ((acc_e'(lk_acc) == ACC_WRITE) ? hit_mask : '0);
    if (inv_valid) begin
      vld_d &= ~inv_match;
      ref_d &= ~inv_match;
      mod_d &= ~inv_match;
    end
    if (fill_valid) begin
      vld_d |= fill_mask;
      ref_d |= fill_mask;
      mod_d &= ~fill_mask;
    end
    touched = hit_mask | (fill_valid ? fill_mask : '0);
    if (&ref_d) ref_d = touched & vld_d;
    if (flush) begin
      vld_d = '0;
      ref_d = '0;
      mod_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ref_q <= '0;
      mod_q <= '0;
    end else begin
      vld_q <= vld_d;
      ref_q <= ref_d;
      mod_q <= mod_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en[i]) begin
        vpn_q[i]  <= fill_vpn;
        asid_q[i] <= fill_asid;
        pfn_q[i]  <= fill_pfn;
        perm_q[i] <= fill_perm;
      end
    end
  end
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int ASID_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [VPN_W-1:0]       lk_vpn,
  input logic [ASID_W-1:0]      lk_asid,
  input logic [OFF_W-1:0]       lk_offset,
  input logic                   lk_hit,
  input logic                   lk_fault,
  input logic                   lk_dirty,
  input logic [PFN_W+OFF_W-1:0] lk_paddr,
  input logic                   fill_valid,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic [ASID_W-1:0]      fill_asid,
  input logic                   inv_valid,
  input logic [VPN_W-1:0]       inv_vpn,
  input logic                   flush
);
  // R3
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_fault && !lk_dirty && lk_paddr == '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_fault) |-> (lk_paddr[OFF_W-1:0] == lk_offset));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  // R5
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(fill_valid && !inv_valid && !flush) &&
     lk_vpn == $past(fill_vpn) && lk_asid == $past(fill_asid)) |-> lk_hit);

  // R9
  inv_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_valid && !fill_valid) && lk_vpn == $past(inv_vpn)) |-> !lk_hit);
endmodule

bind tlb_assoc tlb_assoc_chk #(
  .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .ASID_W(ASID_W)
) u_chk (.*);

// File: tb/tb_tlb_assoc.sv
module tb_tlb_assoc;
  localparam int ENT = 32, VW = 20, PW = 20, OW = 12, AW = 8;

  logic clk, rst_n;
  logic lk_valid, lk_user, lk_hit, lk_fault, lk_dirty;
  logic [VW-1:0] lk_vpn, fill_vpn, inv_vpn;
  logic [AW-1:0] lk_asid, fill_asid;
  logic [OW-1:0] lk_offset;
  logic [1:0]    lk_acc;
  logic [PW+OW-1:0] lk_paddr;
  logic fill_valid, inv_valid, flush;
  logic [PW-1:0] fill_pfn;
  logic [3:0]    fill_perm;

  tlb_assoc #(.ENTRIES(ENT), .VPN_W(VW), .PFN_W(PW), .OFF_W(OW), .ASID_W(AW)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  bit          m_v [ENT], m_ref [ENT], m_mod [ENT];
  bit [VW-1:0] m_vpn [ENT];
  bit [AW-1:0] m_asid [ENT];
  bit [PW-1:0] m_pfn [ENT];
  bit [3:0]    m_perm [ENT];

  function automatic bit permitted(bit [3:0] p, bit [1:0] acc, bit user);
    bit need;
    case (acc)
      2'd0: need = p[0];
      2'd1: need = p[1];
      2'd2: need = p[2];
      default: need = 1'b0;
    endcase
    return need && (!user || p[3]);
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit lv, bit [VW-1:0] vpn, bit [AW-1:0] asid, bit [OW-1:0] off,
                      bit [1:0] acc, bit user, bit fv, bit [VW-1:0] fvpn, bit [AW-1:0] fasid,
                      bit [PW-1:0] fpfn, bit [3:0] fperm, bit iv, bit [VW-1:0] ivpn, bit fl);
    bit mhit, ok, anyinv, anyclr, allref;
    int idx, tgt, vic_inv, vic_ref;
    bit [ENT-1:0] touch;
    @(negedge clk);
    lk_valid = lv; lk_vpn = vpn; lk_asid = asid; lk_offset = off; lk_acc = acc; lk_user = user;
    fill_valid = fv; fill_vpn = fvpn; fill_asid = fasid; fill_pfn = fpfn; fill_perm = fperm;
    inv_valid = iv; inv_vpn = ivpn; flush = fl;
    #1;
    mhit = 1'b0; idx = 0;
    for (int i = 0; i < ENT; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) begin mhit = lv; idx = i; end
    ok = mhit && permitted(m_perm[idx], acc, user);
    check(tag, "hit", 64'(lk_hit), 64'(mhit));
    check(tag, "fault", 64'(lk_fault), 64'(mhit && !ok));
    check(tag, "dirty", 64'(lk_dirty), 64'(mhit && m_mod[idx]));
    check(tag, "paddr", 64'(lk_paddr), ok ? 64'({m_pfn[idx], off}) : 64'(0));
    @(posedge clk);
    // model update from the state before this edge
    tgt = -1; vic_inv = -1; vic_ref = -1; touch = '0;
    for (int i = ENT - 1; i >= 0; i--) begin
      if (m_v[i] && m_vpn[i] == fvpn && m_asid[i] == fasid) tgt = i;
      if (!m_v[i]) vic_inv = i;
      if (!m_ref[i]) vic_ref = i;
    end
    if (tgt < 0) tgt = (vic_inv >= 0) ? vic_inv : ((vic_ref >= 0) ? vic_ref : 0);
    if (ok) begin
      m_ref[idx] = 1'b1;
      if (acc == 2'd1) m_mod[idx] = 1'b1;
      touch[idx] = 1'b1;
    end
    if (iv)
      for (int i = 0; i < ENT; i++)
        if (m_v[i] && m_vpn[i] == ivpn) begin m_v[i] = 0; m_ref[i] = 0; m_mod[i] = 0; end
    if (fv) begin
      m_v[tgt] = 1; m_ref[tgt] = 1; m_mod[tgt] = 0;
      m_vpn[tgt] = fvpn; m_asid[tgt] = fasid; m_pfn[tgt] = fpfn; m_perm[tgt] = fperm;
      touch[tgt] = 1'b1;
    end
    allref = 1'b1;
    for (int i = 0; i < ENT; i++) if (!m_ref[i]) allref = 1'b0;
    if (allref) for (int i = 0; i < ENT; i++) m_ref[i] = touch[i] && m_v[i];
    if (fl) for (int i = 0; i < ENT; i++) begin m_v[i] = 0; m_ref[i] = 0; m_mod[i] = 0; end
    anyinv = 0; anyclr = 0;
  endtask

  // shorthands
  task automatic look(string tag, bit [VW-1:0] vpn, bit [AW-1:0] asid, bit [1:0] acc, bit user);
    step(tag, 1, vpn, asid, 12'h5a5, acc, user, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic put(string tag, bit [VW-1:0] vpn, bit [AW-1:0] asid, bit [PW-1:0] pfn, bit [3:0] perm);
    step(tag, 0, 0, 0, 0, 0, 0, 1, vpn, asid, pfn, perm, 0, 0, 0);
  endtask

  initial begin
    #(300000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    for (int i = 0; i < ENT; i++) begin m_v[i] = 0; m_ref[i] = 0; m_mod[i] = 0; end
    rst_n = 1'b0;
    lk_valid = 0; lk_vpn = 0; lk_asid = 0; lk_offset = 0; lk_acc = 0; lk_user = 0;
    fill_valid = 0; fill_vpn = 0; fill_asid = 0; fill_pfn = 0; fill_perm = 0;
    inv_valid = 0; inv_vpn = 0; flush = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 empty after reset
    look("R1", 5, 1, 0, 0);
    // R5 same-cycle fill and lookup misses, then hits
    step("R5", 1, 5, 1, 12'h123, 0, 0, 1, 5, 1, 20'hABCDE, 4'b1111, 0, 0, 0);
    look("R5 R2", 5, 1, 0, 1);
    look("R2 asid", 5, 0, 0, 0);
    // R3 permission checks on a kernel read-only entry
    put("R3", 6, 1, 20'h00777, 4'b0001);
    look("R3 kread", 6, 1, 0, 0);
    look("R3 write", 6, 1, 1, 0);
    look("R3 user", 6, 1, 0, 1);
    look("R3 exec", 6, 1, 2, 0);
    look("R3 rsvd", 6, 1, 3, 0);
    // R4 write sets modify; reported from the next access
    look("R4 write", 5, 1, 1, 1);
    look("R4 dirty", 5, 1, 0, 0);
    // R11 idle lookup on a present page
    step("R11", 0, 5, 1, 12'hfff, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 refill in place
    put("R6", 5, 1, 20'h13579, 4'b1111);
    look("R6", 5, 1, 0, 0);
    // R9 invalidate across tags
    put("R9", 7, 0, 20'h00070, 4'b0111);
    put("R9", 7, 1, 20'h00071, 4'b0111);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7, 0);
    look("R9 t0", 7, 0, 0, 0);
    look("R9 t1", 7, 1, 0, 0);
    look("R9 keep", 5, 1, 0, 0);
    // R10 flush overrides fill
    step("R10", 0, 0, 0, 0, 0, 0, 1, 8, 0, 20'h8, 4'b0001, 0, 0, 1);
    look("R10", 8, 0, 0, 0);
    look("R10", 5, 1, 0, 0);
    // R7 fill empty entries in order; R8 NRU once full
    for (int i = 0; i < ENT; i++) put("R7", VW'(100 + i), 2, PW'(16'h1000 + i), 4'b0001);
    for (int i = 0; i < ENT; i++) look("R7", VW'(100 + i), 2, 3, 0);
    put("R8", 200, 2, 20'h200, 4'b0001);
    look("R8 evict0", 100, 2, 0, 0);
    look("R8 keep1", 101, 2, 0, 0);
    put("R8", 201, 2, 20'h201, 4'b0001);
    look("R8 evict2", 102, 2, 0, 0);
    look("R8 keep3", 103, 2, 0, 0);
    look("R8 new", 201, 2, 0, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      step("random R2 R3 R4 R8", ($urandom % 5) != 0, VW'($urandom % 48), AW'($urandom % 2),
           OW'($urandom), 2'($urandom), 1'($urandom),
           ($urandom % 10) < 3, VW'($urandom % 48), AW'($urandom % 2), PW'($urandom), 4'($urandom),
           ($urandom % 32) == 0, VW'($urandom % 48), ($urandom % 128) == 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule